// File: doc/BRIEF.md
# Pilot ground trip delay logic

This block decides when a line-protection terminal issues its pilot ground trip. Two clean logic inputs can cause the trip. The pilot distance ground element trips at once, is always in service, and wins whenever both paths qualify. The forward directional overcurrent ground element trips only after it has stayed asserted for a programmed number of power-system cycles.

The cycle count advances on a one-clock strobe that marks each power-system cycle. A 5-bit setting selects a delay of 0 to 15 cycles. Any other value takes the delayed path out of service. The block raises a warning flag when an in-service delay is set below 3 cycles, because such short settings weaken security.

The outputs are a registered trip request and a two-bit cause code that shows which path produced it. Measuring phasors, running the directional algorithms and driving the breaker are all done elsewhere.

Top module: `pgt_trip_top`

## Requirements
- R1: While reset is asserted and after its release with all inputs low, `trip_o` is 0 and `cause_o` is 2'b00.
- R2: If `dist_gnd_i` is high at a clock edge, then after that edge `trip_o` is 1 and `cause_o` is 2'b01, whatever `dly_set_i` holds (blocked values included).
- R3: With `dly_set_i` = N in 1..15 and `ocg_fwd_i` held high, `trip_o` stays 0 through the edge that samples the N-th `cyc_stb_i` pulse. It rises with `cause_o` = 2'b10 at the next edge.
- R4: With `dly_set_i` = 0, `ocg_fwd_i` high at an edge gives `trip_o` = 1 and `cause_o` = 2'b10 after that same edge.
- R5: An edge that samples `ocg_fwd_i` low clears the count of strobes seen, so the full delay restarts when the input returns.
- R6: Setting values 16 to 31 are blocked: `ocg_fwd_i` never causes a trip, however many strobes pass.
- R7: When both inputs qualify at the same edge, `cause_o` reports 2'b01 (distance).
- R8: An edge at which no cause qualifies clears `trip_o` to 0 and `cause_o` to 2'b00.
- R9: `low_dly_warn_o` is 1 for settings 0, 1 and 2, and 0 for settings 3..15 and 16..31. It follows `dly_set_i` without a clock.
- R10: Only `cyc_stb_i` advances the delay. With N >= 1 and no strobe, `ocg_fwd_i` held high never trips.
- R11: `cause_o` is never 2'b11, and `trip_o` is 1 exactly when `cause_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dist_gnd_i | input | 1 | Pilot distance ground element asserted |
| ocg_fwd_i | input | 1 | Forward directional overcurrent ground element asserted |
| cyc_stb_i | input | 1 | One-clock pulse per power-system cycle |
| dly_set_i | input | 5 | Delay in cycles (0..15); 16..31 blocks the delayed path |
| trip_o | output | 1 | Pilot ground trip request |
| cause_o | output | 2 | 00 none, 01 distance, 10 delayed overcurrent |
| low_dly_warn_o | output | 1 | In-service delay setting below 3 cycles |

## Verification
The hardest situation to reach is the exact edge where the delayed path times out. Getting there needs a long, unbroken run of the overcurrent input together with a counted number of strobes. A restart caused by a one-clock dropout must also fall in the middle of that run. The directed tasks clear the count first by holding the input low for one edge. They then issue strobes one at a time and check the output before and after the edge that samples the final strobe. One task inserts a single-edge dropout after two of three strobes, to show that the count starts over.

// File: rtl/pgt_pkg.sv
package pgt_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_DIST = 2'b01,
    CAUSE_OCG  = 2'b10
  } cause_e;
endpackage

// File: rtl/pgt_setting_dec.sv
module pgt_setting_dec #(
  parameter int SET_W      = 5,
  parameter int DLY_W      = 4,
  parameter int WARN_BELOW = 3
) (
  input  logic [SET_W-1:0] set_i,
  output logic [DLY_W-1:0] dly_o,
  output logic             blocked_o,
  output logic             warn_o
);
  localparam int MAX_DLY = (1 << DLY_W) - 1;
  localparam logic [SET_W-1:0] MAX_SET  = SET_W'(MAX_DLY);
  localparam logic [SET_W-1:0] WARN_LIM = SET_W'(WARN_BELOW);

  always_comb begin
    blocked_o = (set_i > MAX_SET);
    dly_o     = set_i[DLY_W-1:0];
    warn_o    = !blocked_o && (set_i < WARN_LIM);
  end
endmodule

// File: rtl/pgt_cycle_timer.sv
module pgt_cycle_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ocg_i,
  input  logic             stb_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             blocked_i,
  output logic             qual_o
);
  localparam logic [DLY_W-1:0] CNT_MAX = '1;

  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = !ocg_i || (stb_i && (cnt_q != CNT_MAX));
    cnt_d  = ocg_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb qual_o = ocg_i && !blocked_i && (cnt_q >= dly_i);
endmodule

// File: rtl/pgt_trip_arb.sv
module pgt_trip_arb
  import pgt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dist_i,
  input  logic       ocg_qual_i,
  output logic       trip_o,
  output logic [1:0] cause_o
);
  cause_e cause_d, cause_q;

  always_comb begin
    if (dist_i)          cause_d = CAUSE_DIST;
    else if (ocg_qual_i) cause_d = CAUSE_OCG;
    else                 cause_d = CAUSE_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= CAUSE_NONE;
    else         cause_q <= cause_d;
  end

  assign cause_o = cause_q;
  assign trip_o  = (cause_q != CAUSE_NONE);
endmodule

// File: rtl/pgt_trip_top.sv
module pgt_trip_top #(
  parameter int SET_W      = 5,
  parameter int DLY_W      = 4,
  parameter int WARN_BELOW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dist_gnd_i,
  input  logic             ocg_fwd_i,
  input  logic             cyc_stb_i,
  input  logic [SET_W-1:0] dly_set_i,
  output logic             trip_o,
  output logic [1:0]       cause_o,
  output logic             low_dly_warn_o
);
  logic [DLY_W-1:0] dly;
  logic             blocked;
  logic             ocg_qual;

  pgt_setting_dec #(.SET_W(SET_W), .DLY_W(DLY_W), .WARN_BELOW(WARN_BELOW)) u_dec (
    .set_i(dly_set_i), .dly_o(dly), .blocked_o(blocked), .warn_o(low_dly_warn_o)
  );

  pgt_cycle_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .ocg_i(ocg_fwd_i), .stb_i(cyc_stb_i),
    .dly_i(dly), .blocked_i(blocked), .qual_o(ocg_qual)
  );

  pgt_trip_arb u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .dist_i(dist_gnd_i), .ocg_qual_i(ocg_qual),
    .trip_o(trip_o), .cause_o(cause_o)
  );
endmodule

module pgt_trip_chk #(
  parameter int SET_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dist_gnd_i,
  input logic             ocg_fwd_i,
  input logic [SET_W-1:0] dly_set_i,
  input logic             trip_o,
  input logic [1:0]       cause_o
);
  localparam logic [SET_W-1:0] FIRST_BLK = SET_W'(16);

  assert_dist_trip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dist_gnd_i |=> (trip_o && cause_o == 2'b01));

  assert_zero_delay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocg_fwd_i && !dist_gnd_i && dly_set_i == '0) |=> (trip_o && cause_o == 2'b10));

  assert_blocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dist_gnd_i && dly_set_i >= FIRST_BLK) |=> !trip_o);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dist_gnd_i && !ocg_fwd_i) |=> (!trip_o && cause_o == 2'b00));

  assert_cause_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o) && (trip_o == (cause_o != 2'b00)));
endmodule

bind pgt_trip_top pgt_trip_chk #(.SET_W(SET_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dist_gnd_i(dist_gnd_i), .ocg_fwd_i(ocg_fwd_i),
  .dly_set_i(dly_set_i), .trip_o(trip_o), .cause_o(cause_o)
);

// File: tb/pgt_trip_top_tb_top.sv
module pgt_trip_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       dist_gnd_i, ocg_fwd_i, cyc_stb_i;
  logic [4:0] dly_set_i;
  logic       trip_o, low_dly_warn_o;
  logic [1:0] cause_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pgt_trip_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .dist_gnd_i(dist_gnd_i), .ocg_fwd_i(ocg_fwd_i),
    .cyc_stb_i(cyc_stb_i), .dly_set_i(dly_set_i), .trip_o(trip_o),
    .cause_o(cause_o), .low_dly_warn_o(low_dly_warn_o)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic t, input logic [1:0] c);
    chk(req, {trip_o, cause_o}, {t, c});
  endtask

  task automatic strobe();
    cyc_stb_i = 1'b1; tick(); cyc_stb_i = 1'b0;
  endtask

  task automatic clear_all();
    dist_gnd_i = 1'b0; ocg_fwd_i = 1'b0; cyc_stb_i = 1'b0; tick();
  endtask

  task automatic t_reset_R1();
    chk_out("R1 in reset", 1'b0, 2'b00);
    rst_ni = 1'b1;
    tick(2);
    chk_out("R1 after release", 1'b0, 2'b00);
  endtask

  task automatic t_dist_R2();
    clear_all();
    dly_set_i = 5'd20;
    dist_gnd_i = 1'b1; tick();
    chk_out("R2 distance with blocked setting", 1'b1, 2'b01);
    dly_set_i = 5'd9; tick();
    chk_out("R2 distance with delay 9", 1'b1, 2'b01);
    dist_gnd_i = 1'b0; tick();
    chk_out("R8 clear after distance", 1'b0, 2'b00);
  endtask

  task automatic t_delay_R3();
    clear_all();
    dly_set_i = 5'd4;
    ocg_fwd_i = 1'b1;
    for (int i = 0; i < 3; i++) begin strobe(); tick(); end
    chk_out("R3 before last strobe", 1'b0, 2'b00);
    strobe();
    chk_out("R3 at last strobe edge", 1'b0, 2'b00);
    tick();
    chk_out("R3 trip after delay", 1'b1, 2'b10);
    ocg_fwd_i = 1'b0; tick();
    chk_out("R8 clear after overcurrent drop", 1'b0, 2'b00);
  endtask

  task automatic t_zero_R4();
    clear_all();
    dly_set_i = 5'd0;
    ocg_fwd_i = 1'b1; tick();
    chk_out("R4 zero delay immediate", 1'b1, 2'b10);
  endtask

  task automatic t_restart_R5();
    clear_all();
    dly_set_i = 5'd3;
    ocg_fwd_i = 1'b1;
    strobe(); strobe();
    ocg_fwd_i = 1'b0; tick();
    ocg_fwd_i = 1'b1;
    strobe(); strobe(); tick();
    chk_out("R5 count restarted", 1'b0, 2'b00);
    strobe(); tick();
    chk_out("R5 trip after full delay", 1'b1, 2'b10);
  endtask

  task automatic t_blocked_R6();
    clear_all();
    dly_set_i = 5'd16;
    ocg_fwd_i = 1'b1;
    for (int i = 0; i < 20; i++) strobe();
    tick();
    chk_out("R6 setting 16 blocked", 1'b0, 2'b00);
    dly_set_i = 5'd27;
    for (int i = 0; i < 20; i++) strobe();
    tick();
    chk_out("R6 setting 27 blocked", 1'b0, 2'b00);
  endtask

  task automatic t_prio_R7();
    clear_all();
    dly_set_i = 5'd0;
    ocg_fwd_i = 1'b1; dist_gnd_i = 1'b1; tick();
    chk_out("R7 distance wins", 1'b1, 2'b01);
    dist_gnd_i = 1'b0; tick();
    chk_out("R7 overcurrent after distance drops", 1'b1, 2'b10);
  endtask

  task automatic t_warn_R9();
    for (int v = 0; v < 32; v++) begin
      dly_set_i = 5'(v);
      #1;
      chk($sformatf("R9 warn setting %0d", v), {2'b00, low_dly_warn_o},
          {2'b00, (v < 3) ? 1'b1 : 1'b0});
    end
  endtask

  task automatic t_nostrobe_R10();
    clear_all();
    dly_set_i = 5'd2;
    ocg_fwd_i = 1'b1;
    tick(50);
    chk_out("R10 no strobe no trip", 1'b0, 2'b00);
    dly_set_i = 5'd15;
    for (int i = 0; i < 15; i++) strobe();
    tick();
    chk_out("R10 max delay after 15 strobes", 1'b1, 2'b10);
  endtask

  initial begin
    rst_ni = 1'b0;
    dist_gnd_i = 1'b0; ocg_fwd_i = 1'b0; cyc_stb_i = 1'b0; dly_set_i = 5'd5;
    tick(3);
    t_reset_R1();
    t_dist_R2();
    t_delay_R3();
    t_zero_R4();
    t_restart_R5();
    t_blocked_R6();
    t_prio_R7();
    t_warn_R9();
    t_nostrobe_R10();
    clear_all();
    chk_out("R11 idle cause code", 1'b0, 2'b00);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule